// File: doc/BRIEF.md
# Instruction-Byte Serial Command Port

This block is the slave side of a chip-select-framed serial port that configures and triggers a data-acquisition front end. Every transaction begins with one instruction byte, shifted in most-significant bit first on the serial data input. If the top bit of that byte is set, the byte is a conversion command. Its gain and channel codes are copied into the configuration register and sent to the analog front end, and a one-cycle start pulse goes to the converter. If the top bit is clear, the byte opens an 8-bit or 16-bit write or read of a small byte-wide register file.

The serial clock, chip select and data input are sampled by the block's own system clock, so each serial clock phase must last several system clocks. A static input selects whether the rising or the falling serial clock edge is active. A second static input enables two-wire operation. In that mode the read data is also driven back onto the data-input pin, through a separate output-enable and data pair.

Top module: `cmd_serial_if`

## Requirements
- R1: An instruction byte with bit 7 = 1 is a conversion command. Bits 6:4 appear on `gainCode` and bits 3:0 appear on `chanCode`.
- R2: A conversion command stores {0, byte[6:0]} into the register at address 4. A later one-byte read of address 4 returns that value.
- R3: Each conversion command raises `convStart` for exactly one system clock, within three system clocks of its eighth active serial edge. Register-mode bytes never raise it.
- R4: An instruction byte with bit 7 = 0 is a register access. Bit 6 = 1 means read and bit 6 = 0 means write. Bit 5 = 1 means two bytes and bit 5 = 0 means one byte. Bits 4:0 hold the address. The written bytes follow the instruction in the same transaction, and a write to address 4 updates `gainCode`/`chanCode`.
- R5: All bytes move most-significant bit first. A two-byte access uses address A for the first (high) byte and A+1 (mod 32) for the second. Read data appears on `sdo` after the active edge that precedes each bit.
- R6: When `edgeSel` = 1, the rising `sclk` edge is the active edge. When `edgeSel` = 0, the falling edge is active. The other edge is ignored.
- R7: While `csN` is high, `sdoOe` and `sdiOe` are low, serial clock edges are ignored, and no register or output changes.
- R8: Raising `csN` partway through a byte discards the partial bits. The first byte after `csN` falls again is decoded as a fresh instruction.
- R9: Raising `csN` right after the eighth edge of a conversion command does not suppress the start pulse or the configuration update.
- R10: An active-low `rstN` clears every register to zero. This sets gain and channel to 0, deasserts `convStart` and disables both output drivers.
- R11: With `twoWire` = 1, during the data bytes of a read, `sdiOe` is high and `sdiOut` equals `sdo`. With `twoWire` = 0, `sdiOe` stays low.
- R12: Addresses at or above NUM_REGS (8 by default) read as 0x00 and ignore writes. This includes the second byte of a two-byte access at the last address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select framing a transaction |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data input |
| edgeSel | input | 1 | Active serial edge: 1 rising, 0 falling |
| twoWire | input | 1 | Also return read data on the data-input pin |
| sdo | output | 1 | Serial data output |
| sdoOe | output | 1 | Drive enable for `sdo` |
| sdiOut | output | 1 | Read data to drive onto the data-input pin |
| sdiOe | output | 1 | Drive enable for the data-input pin |
| gainCode | output | 3 | Amplifier gain code |
| chanCode | output | 4 | Multiplexer channel code |
| convStart | output | 1 | One-cycle conversion start pulse |

## Verification
The assertions assume that `csN` is high while `rstN` is low. They also assume that `sclk`, `sdi`, `edgeSel` and `twoWire` change only on the falling system clock edge. The chip-select properties count cycles through the one-stage input sampler, so they assume that the whole block sees chip select only through that sampler. The stimulus holds every serial clock phase for four system clocks. It sets `sdi` during the inactive phase and changes `edgeSel` only while chip select is high, so each serial edge is seen exactly once.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {PH_INSTR, PH_WDATA, PH_RDATA} phase_t;

  typedef struct packed {
    logic              shiftIn;
    logic              shiftOut;
    logic              loadOut;
    logic              wrByte;
    logic              mirror;
    logic              readPhase;
    logic [ADDR_W-1:0] addr;
  } dpStrobe_t;
endpackage

// File: rtl/cmdif_ctrl.sv
module cmdif_ctrl
  import cmdif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              edgeSel,
  input  logic [BYTE_W-1:0] nextByte,
  output dpStrobe_t         stb,
  output logic              convStart,
  output logic              ifActive
);
  logic              sclkQ, sclkPrev, csQ;
  phase_t            phase;
  logic [2:0]        bitCnt;
  logic [ADDR_W-1:0] curAddr;
  logic              twoLeft;
  logic              edgeHit, byteDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      sclkPrev <= 1'b0;
      csQ      <= 1'b1;
    end else begin
      sclkQ    <= sclk;
      sclkPrev <= sclkQ;
      csQ      <= csN;
    end
  end

  assign edgeHit  = !csQ && (edgeSel ? (sclkQ && !sclkPrev) : (!sclkQ && sclkPrev));
  assign byteDone = edgeHit && (bitCnt == 3'd7);
  assign ifActive = !csQ;

  always_comb begin
    stb           = '0;
    stb.shiftIn   = edgeHit;
    stb.readPhase = (phase == PH_RDATA);
    stb.addr      = curAddr;
    if (byteDone) begin
      unique case (phase)
        PH_INSTR: begin
          if (nextByte[7]) begin
            stb.mirror = 1'b1;
          end else if (nextByte[6]) begin
            stb.loadOut = 1'b1;
            stb.addr    = nextByte[ADDR_W-1:0];
          end
        end
        PH_WDATA: stb.wrByte = 1'b1;
        PH_RDATA: begin
          if (twoLeft) begin
            stb.loadOut = 1'b1;
            stb.addr    = curAddr + ADDR_W'(1);
          end
        end
        default: ;
      endcase
    end
    if (edgeHit && (phase == PH_RDATA) && !stb.loadOut) stb.shiftOut = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_INSTR;
      bitCnt    <= '0;
      curAddr   <= '0;
      twoLeft   <= 1'b0;
      convStart <= 1'b0;
    end else begin
      convStart <= byteDone && (phase == PH_INSTR) && nextByte[7];
      if (csQ) begin
        phase   <= PH_INSTR;
        bitCnt  <= '0;
        twoLeft <= 1'b0;
      end else if (edgeHit) begin
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          if (phase == PH_INSTR) begin
            if (!nextByte[7]) begin
              curAddr <= nextByte[ADDR_W-1:0];
              twoLeft <= nextByte[5];
              phase   <= nextByte[6] ? PH_RDATA : PH_WDATA;
            end
          end else if (twoLeft) begin
            curAddr <= curAddr + ADDR_W'(1);
            twoLeft <= 1'b0;
          end else begin
            phase <= PH_INSTR;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cmdif_datapath.sv
module cmdif_datapath
  import cmdif_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int MIRROR_ADDR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  dpStrobe_t         stb,
  output logic [BYTE_W-1:0] nextByte,
  output logic              sdo,
  output logic [2:0]        gainCode,
  output logic [3:0]        chanCode
);
  logic              sdiQ;
  logic [BYTE_W-1:0] inShift, outShift, readByte;
  logic [BYTE_W-1:0] regs [NUM_REGS];

  assign nextByte = {inShift[BYTE_W-2:0], sdiQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdiQ    <= 1'b0;
      inShift <= '0;
    end else begin
      sdiQ <= sdi;
      if (stb.shiftIn) inShift <= nextByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (stb.mirror && (i == MIRROR_ADDR))
          regs[i] <= {1'b0, nextByte[BYTE_W-2:0]};
        else if (stb.wrByte && (stb.addr == ADDR_W'(i)))
          regs[i] <= nextByte;
      end
    end
  end

  always_comb begin
    readByte = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (stb.addr == ADDR_W'(i)) readByte = regs[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outShift <= '0;
    else if (stb.loadOut)  outShift <= readByte;
    else if (stb.shiftOut) outShift <= {outShift[BYTE_W-2:0], 1'b0};
  end

  assign sdo      = stb.readPhase & outShift[BYTE_W-1];
  assign gainCode = regs[MIRROR_ADDR][6:4];
  assign chanCode = regs[MIRROR_ADDR][3:0];
endmodule

// File: rtl/cmd_serial_if.sv
module cmd_serial_if
  import cmdif_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int MIRROR_ADDR = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       edgeSel,
  input  logic       twoWire,
  output logic       sdo,
  output logic       sdoOe,
  output logic       sdiOut,
  output logic       sdiOe,
  output logic [2:0] gainCode,
  output logic [3:0] chanCode,
  output logic       convStart
);
  dpStrobe_t         stb;
  logic [BYTE_W-1:0] nextByte;
  logic              ifActive;

  cmdif_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .edgeSel(edgeSel),
    .nextByte(nextByte), .stb(stb), .convStart(convStart), .ifActive(ifActive)
  );

  cmdif_datapath #(.NUM_REGS(NUM_REGS), .MIRROR_ADDR(MIRROR_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .sdi(sdi), .stb(stb), .nextByte(nextByte),
    .sdo(sdo), .gainCode(gainCode), .chanCode(chanCode)
  );

  assign sdoOe  = ifActive;
  assign sdiOe  = ifActive & twoWire & stb.readPhase;
  assign sdiOut = sdo;
endmodule

// File: rtl/cmdif_chk.sv
module cmdif_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       twoWire,
  input logic       sdo,
  input logic       sdoOe,
  input logic       sdiOut,
  input logic       sdiOe,
  input logic [2:0] gainCode,
  input logic [3:0] chanCode,
  input logic       convStart
);
  // R3
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R7
  cs_idle_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> !sdoOe);

  // R7
  cs_idle_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN, 2) |-> $stable({gainCode, chanCode}));

  // R7
  cs_idle_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN, 2) |-> !convStart);

  // R11
  two_wire_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdiOe |-> (sdoOe && twoWire && (sdiOut == sdo)));

  // R11
  two_wire_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !twoWire |-> !sdiOe);
endmodule

bind cmd_serial_if cmdif_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .twoWire(twoWire), .sdo(sdo),
  .sdoOe(sdoOe), .sdiOut(sdiOut), .sdiOe(sdiOe), .gainCode(gainCode),
  .chanCode(chanCode), .convStart(convStart)
);

// File: tb/cmd_serial_if_bench.sv
module cmd_serial_if_bench;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0, edgeSel = 1'b1, twoWire = 1'b0;
  logic sdo, sdoOe, sdiOut, sdiOe, convStart;
  logic [2:0] gainCode;
  logic [3:0] chanCode;

  int checks = 0, errors = 0, convCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmd_serial_if u_cmd_serial_if (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .edgeSel(edgeSel), .twoWire(twoWire), .sdo(sdo), .sdoOe(sdoOe),
    .sdiOut(sdiOut), .sdiOe(sdiOe), .gainCode(gainCode),
    .chanCode(chanCode), .convStart(convStart)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---- behavioural reference model, evaluated on every clock ----
  int mRegs [32];
  bit qS, pS, qC, qD, hit, mTwo, expConv;
  int mPhase, mBits, mAddr;
  bit [7:0] mSh, b;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (mRegs[i]) mRegs[i] = 0;
      qS = 0; pS = 0; qC = 1; qD = 0; mTwo = 0; expConv = 0;
      mPhase = 0; mBits = 0; mAddr = 0; mSh = 0;
    end else begin
      hit = !qC && (edgeSel ? (qS && !pS) : (!qS && pS));
      expConv = 0;
      if (qC) begin
        mBits = 0; mPhase = 0; mTwo = 0;
      end else if (hit) begin
        b = {mSh[6:0], qD};
        mSh = b;
        mBits++;
        if (mBits == 8) begin
          mBits = 0;
          if (mPhase == 0) begin
            if (b[7]) begin
              mRegs[4] = int'(b & 8'h7F);
              expConv = 1;
            end else begin
              mAddr = int'(b[4:0]); mTwo = b[5]; mPhase = b[6] ? 2 : 1;
            end
          end else begin
            if (mPhase == 1 && mAddr < NREG) mRegs[mAddr] = int'(b);
            if (mTwo) begin mAddr = (mAddr + 1) % 32; mTwo = 0; end
            else mPhase = 0;
          end
        end
      end
      pS = qS; qS = sclk; qC = csN; qD = sdi;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(gainCode == 3'((mRegs[4] >> 4) & 7), "R1", "gainCode", gainCode, (mRegs[4] >> 4) & 7);
      check(chanCode == 4'(mRegs[4] & 15), "R1", "chanCode", chanCode, mRegs[4] & 15);
      check(convStart == expConv, "R3", "convStart", convStart, expConv);
      check(sdoOe == !qC, "R7", "sdoOe", sdoOe, !qC);
      check(sdiOe == (!qC && twoWire && mPhase == 2), "R11", "sdiOe", sdiOe,
            (!qC && twoWire && mPhase == 2));
      check(sdiOut == sdo, "R11", "sdiOut", sdiOut, sdo);
    end
    if (convStart) convCnt++;
  end

  // ---- stimulus helpers ----
  int twoWireHits;

  task automatic sendBit(input bit v, output bit got);
    sdi = v;
    repeat (4) @(negedge clk);
    got = sdo;
    if (sdiOe && sdiOut == sdo) twoWireHits++;
    sclk = edgeSel;
    repeat (4) @(negedge clk);
    sclk = ~edgeSel;
  endtask

  task automatic xferByte(input bit [7:0] tx, output bit [7:0] rx);
    for (int i = 7; i >= 0; i--) sendBit(tx[i], rx[i]);
  endtask

  task automatic csLow();
    csN = 0; repeat (3) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (3) @(negedge clk); csN = 1; repeat (3) @(negedge clk);
  endtask

  task automatic setEdge(input bit mode);
    edgeSel = mode; sclk = ~mode; repeat (4) @(negedge clk);
  endtask

  task automatic direct(input bit [7:0] cmd);
    bit [7:0] r;
    csLow(); xferByte(cmd, r); csHigh();
  endtask

  task automatic regWrite(input bit [4:0] a, input bit two, input bit [15:0] d);
    bit [7:0] r;
    csLow();
    xferByte({2'b00, two, a}, r);
    if (two) xferByte(d[15:8], r);
    xferByte(d[7:0], r);
    csHigh();
  endtask

  task automatic regRead(input bit [4:0] a, input bit two, output bit [15:0] v);
    bit [7:0] r, hi;
    csLow();
    xferByte({2'b01, two, a}, r);
    hi = 0;
    if (two) xferByte(8'h00, hi);
    xferByte(8'h00, r);
    v = two ? {hi, r} : {8'h00, r};
    csHigh();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] v;
    bit dummy;
    int c0;
    repeat (5) @(negedge clk);
    // R10 reset state
    check(gainCode == 0 && chanCode == 0, "R10", "cfg after reset", {gainCode, chanCode}, 0);
    check(convStart == 0 && sdoOe == 0 && sdiOe == 0, "R10", "outputs after reset",
          {convStart, sdoOe, sdiOe}, 0);
    rstN = 1;
    repeat (4) @(negedge clk);

    // R1 / R3 conversion command
    c0 = convCnt;
    direct(8'hB5);
    check(gainCode == 3'd3, "R1", "gain after 0xB5", gainCode, 3);
    check(chanCode == 4'd5, "R1", "chan after 0xB5", chanCode, 5);
    check(convCnt == c0 + 1, "R3", "start pulses", convCnt, c0 + 1);

    // R2 mirror register readable
    regRead(5'd4, 0, v);
    check(v == 16'h0035, "R2", "read addr 4", v, 16'h35);

    // R4 one-byte write/read, no start pulse
    c0 = convCnt;
    regWrite(5'd2, 0, 16'h00A7);
    regRead(5'd2, 0, v);
    check(v == 16'h00A7, "R4", "read addr 2", v, 16'hA7);
    check(convCnt == c0, "R3", "no pulse in register mode", convCnt, c0);

    // R5 two-byte ordering
    regWrite(5'd0, 1, 16'h1234);
    regRead(5'd0, 0, v);
    check(v == 16'h0012, "R5", "high byte at addr 0", v, 16'h12);
    regRead(5'd1, 0, v);
    check(v == 16'h0034, "R5", "low byte at addr 1", v, 16'h34);
    regRead(5'd0, 1, v);
    check(v == 16'h1234, "R5", "two-byte read", v, 16'h1234);

    // R6 falling-edge mode
    setEdge(0);
    regWrite(5'd3, 0, 16'h005C);
    regRead(5'd3, 0, v);
    check(v == 16'h005C, "R6", "falling-edge read addr 3", v, 16'h5C);
    c0 = convCnt;
    direct(8'h9A);
    check(gainCode == 3'd1 && chanCode == 4'hA, "R6", "falling-edge command",
          {gainCode, chanCode}, {3'd1, 4'hA});
    check(convCnt == c0 + 1, "R6", "falling-edge pulse", convCnt, c0 + 1);
    setEdge(1);

    // R8 abort partway through a byte
    c0 = convCnt;
    csLow();
    for (int i = 0; i < 4; i++) sendBit(1'b1, dummy);
    csHigh();
    direct(8'h83);
    check(gainCode == 3'd0 && chanCode == 4'd3, "R8", "cfg after abort",
          {gainCode, chanCode}, {3'd0, 4'd3});
    check(convCnt == c0 + 1, "R8", "pulses after abort", convCnt, c0 + 1);

    // R12 out-of-range addresses
    regWrite(5'd20, 0, 16'h00FF);
    regRead(5'd20, 0, v);
    check(v == 16'h0000, "R12", "read addr 20", v, 0);
    regWrite(5'd7, 1, 16'hC399);
    regRead(5'd7, 1, v);
    check(v == 16'hC300, "R12", "two-byte at last address", v, 16'hC300);

    // R4 register write to the configuration register
    c0 = convCnt;
    regWrite(5'd4, 0, 16'h0047);
    check(gainCode == 3'd4 && chanCode == 4'd7, "R4", "cfg via register write",
          {gainCode, chanCode}, {3'd4, 4'd7});
    check(convCnt == c0, "R4", "no pulse on register write", convCnt, c0);

    // R11 two-wire read
    twoWire = 1;
    twoWireHits = 0;
    regRead(5'd2, 0, v);
    check(v == 16'h00A7, "R11", "two-wire read", v, 16'hA7);
    check(twoWireHits == 8, "R11", "bits driven on data-input pin", twoWireHits, 8);
    twoWire = 0;

    // R9 chip select raised right after the eighth edge
    c0 = convCnt;
    csLow();
    begin
      bit [7:0] cmd = 8'hE1;
      for (int i = 7; i >= 1; i--) sendBit(cmd[i], dummy);
      sdi = cmd[0];
      repeat (4) @(negedge clk);
      sclk = edgeSel;
      @(negedge clk);
      csN = 1;
      repeat (4) @(negedge clk);
      sclk = ~edgeSel;
      repeat (4) @(negedge clk);
    end
    check(convCnt == c0 + 1, "R9", "pulse survives chip select", convCnt, c0 + 1);
    check(gainCode == 3'd6 && chanCode == 4'd1, "R9", "cfg survives chip select",
          {gainCode, chanCode}, {3'd6, 4'd1});

    // R7 serial clocks ignored while deselected
    c0 = convCnt;
    sdi = 1;
    for (int i = 0; i < 16; i++) begin
      sclk = ~sclk; repeat (3) @(negedge clk);
    end
    sclk = ~edgeSel; repeat (4) @(negedge clk);
    check(gainCode == 3'd6 && chanCode == 4'd1, "R7", "cfg while deselected",
          {gainCode, chanCode}, {3'd6, 4'd1});
    check(convCnt == c0 && sdoOe == 0, "R7", "no activity while deselected",
          {convCnt[7:0], sdoOe}, {c0[7:0], 1'b0});
    regRead(5'd2, 0, v);
    check(v == 16'h00A7, "R7", "register kept while deselected", v, 16'hA7);

    // R10 reset clears registers
    @(negedge clk); rstN = 0;
    repeat (3) @(negedge clk);
    check(gainCode == 0 && chanCode == 0 && sdoOe == 0, "R10", "outputs in reset",
          {gainCode, chanCode, sdoOe}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    regRead(5'd2, 0, v);
    check(v == 16'h0000, "R10", "addr 2 after reset", v, 0);
    regRead(5'd4, 0, v);
    check(v == 16'h0000, "R10", "addr 4 after reset", v, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule